// File: doc/BRIEF.md
# Dual-Source CPU Clock Controller

This block turns a fast main clock and a slow subsystem clock into the enable pulse that paces the processor's machine cycles. Everything runs on one reference clock at the main-oscillator rate. Each cycle of that clock is one main-clock edge while the main oscillator runs. The subsystem clock arrives as a synchronous one-cycle strobe. Two small control registers are written by the processor. The processor mode register chooses how far the main clock is divided. The system mode register chooses the source and can shut down the main oscillator once the subsystem clock is in use.

Two standby flip-flops gate the machine-cycle enable. A sleep instruction strobe sets the light-sleep flop. Reset or a wake request from the interrupt logic clears it, and while it is set the peripheral tap keeps running. A freeze instruction strobe sets the deep-sleep flop. This also halts the main oscillator and clears the upper two bits of the processor mode register. Only reset or the settling-done pulse from the interval timer clears it. A prescaler tap gives peripherals a pulse at a power-of-two fraction of the main clock.

Top module: `cpuclk_ctrl`

## Requirements
- R1: After reset, pcc_q = 0, scc_q = 0, halted = 0, stopped = 0, main_run = 1, src_sub = 0, and cpu_ce pulses once every 64 clocks.
- R2: With the main source active, pcc_q[1:0] sets the cpu_ce period: 2'b11 gives 4 clocks, 2'b10 gives 8 clocks, and 2'b00 or 2'b01 gives 64 clocks.
- R3: When scc_q[0] = 1 (subsystem selected), src_sub becomes 1 and cpu_ce pulses once every 4 sub_tick strobes.
- R4: A new divide ratio or source takes effect only when the current machine cycle ends. A cycle already under way completes with its old length.
- R5: An scc write stores wdata[0] into scc_q[0]. It sets scc_q[1] only if both wdata[0] and the stored scc_q[0] are 1; otherwise scc_q[1] becomes 0.
- R6: While scc_q[1] = 1 and src_sub = 1, main_run = 0 and per_ce stays low, and cpu_ce keeps its subsystem period.
- R7: A halt_cmd strobe sets halted and suppresses cpu_ce while per_ce continues. An irq_rel strobe clears halted and cpu_ce resumes.
- R8: A stop_cmd strobe sets stopped, forces main_run = 0 and clears pcc_q[3:2], and it silences both cpu_ce and per_ce. irq_rel does not clear stopped. A wt_rel strobe clears it and cpu_ce resumes.
- R9: per_ce pulses once every 2^(3+s) main clocks, where s is tap_sel clamped to at most 9. This gives ratios from 1/8 to 1/4096.
- R10: Reset clears both halted and stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock at the main-oscillator rate |
| rst_n | input | 1 | Synchronous active-low reset |
| sub_tick | input | 1 | One-cycle strobe per subsystem clock edge |
| pcc_we | input | 1 | Processor mode register write strobe |
| pcc_wdata | input | 4 | Processor mode register write data |
| scc_we | input | 1 | System mode register write strobe |
| scc_wdata | input | 2 | Bit 0 source select (1 = subsystem), bit 1 main oscillator off |
| halt_cmd | input | 1 | Light-sleep instruction strobe |
| stop_cmd | input | 1 | Deep-sleep instruction strobe |
| irq_rel | input | 1 | Wake request from the interrupt logic |
| wt_rel | input | 1 | Settling-done pulse from the interval timer |
| tap_sel | input | 4 | Peripheral prescaler tap select |
| cpu_ce | output | 1 | Machine-cycle enable pulse |
| per_ce | output | 1 | Peripheral prescaler tap pulse |
| main_run | output | 1 | Main oscillator running |
| halted | output | 1 | Light-sleep flop state |
| stopped | output | 1 | Deep-sleep flop state |
| pcc_q | output | 4 | Processor mode register contents |
| scc_q | output | 2 | System mode register contents |
| src_sub | output | 1 | Source actually driving the cycle counter (1 = subsystem) |

## Verification
The machine-cycle period is measured for all four codes of the divide field and for the subsystem source. This separates the two codes that share the 64 ratio from the 4 and 8 ratios, and it separates main pacing from strobe pacing. A ratio change written five clocks into a 64-clock cycle shows that the old cycle finishes at full length before the new period appears. All ten prescaler taps and one clamped select value are timed, so each exponent and the clamp are checked. The two sleep states are driven with both release strobes, so that each flop is shown to answer only its own release path.

// File: rtl/ckc_pkg.sv
// Shared types and helpers for the CPU clock controller.
// Assumes a main-clock ratio of at most MAX_DIV reference clocks.
package ckc_pkg;

    localparam int MAX_DIV = 64;

    typedef enum logic [1:0] {
        DIV64 = 2'd0,
        DIV8  = 2'd1,
        DIV4  = 2'd2
    } div_e;

    // Map the two low processor-mode bits to a divide choice.
    function automatic div_e pcc_decode(input logic [1:0] bits);
        case (bits)
            2'b11:   return DIV4;
            2'b10:   return DIV8;
            default: return DIV64;
        endcase
    endfunction

    // Number of main clocks in one machine cycle for a divide choice.
    function automatic logic [7:0] div_ratio(input div_e d);
        case (d)
            DIV4:    return 8'd4;
            DIV8:    return 8'd8;
            default: return 8'd64;
        endcase
    endfunction

endpackage

// File: rtl/ckc_regs.sv
// Processor mode and system mode registers.
// The oscillator-off bit is accepted only when the source bit is already
// set and is being written as set. A freeze strobe wipes the upper mode bits.
module ckc_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pcc_we,
    input  logic [3:0] pcc_wdata,
    input  logic       scc_we,
    input  logic [1:0] scc_wdata,
    input  logic       stop_cmd,
    output logic [3:0] pcc_q,
    output logic [1:0] scc_q
);

    // Processor mode register; the freeze strobe overrides a same-cycle write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcc_q <= 4'd0;
        end else begin
            if (pcc_we)
                pcc_q <= pcc_wdata;
            if (stop_cmd)
                pcc_q[3:2] <= 2'b00;
        end
    end

    // System mode register with the guarded oscillator-off bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scc_q <= 2'd0;
        end else if (scc_we) begin
            scc_q[0] <= scc_wdata[0];
            scc_q[1] <= scc_wdata[1] & scc_wdata[0] & scc_q[0];
        end
    end

endmodule

// File: rtl/ckc_standby.sv
// Light-sleep and deep-sleep flip-flops.
// Each flop has its own release strobe. A release wins over a set
// arriving in the same cycle. Assumes strobes last one clock.
module ckc_standby (
    input  logic clk,
    input  logic rst_n,
    input  logic halt_cmd,
    input  logic stop_cmd,
    input  logic irq_rel,
    input  logic wt_rel,
    output logic halt_q,
    output logic stop_q
);

    // Light sleep: set by instruction, cleared by interrupt wake.
    always_ff @(posedge clk) begin
        if (!rst_n)
            halt_q <= 1'b0;
        else if (irq_rel)
            halt_q <= 1'b0;
        else if (halt_cmd)
            halt_q <= 1'b1;
    end

    // Deep sleep: set by instruction, cleared only by timer settling pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stop_q <= 1'b0;
        else if (wt_rel)
            stop_q <= 1'b0;
        else if (stop_cmd)
            stop_q <= 1'b1;
    end

endmodule

// File: rtl/ckc_cycle.sv
// Machine-cycle generator. It counts ticks of the active source and
// emits cpu_ce at the end of each cycle, unless a sleep flop is set.
// Source and ratio are sampled only at a cycle end, so no cycle is cut short.
module ckc_cycle
    import ckc_pkg::*;
#(
    parameter int SUB_DIV = 4,
    localparam int CYC_W  = $clog2(MAX_DIV)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic main_tick,
    input  logic sub_tick,
    input  logic sel_sub,
    input  div_e sel_div,
    input  logic halt_q,
    input  logic stop_q,
    output logic act_sub,
    output div_e act_div,
    output logic cyc_end,
    output logic cpu_ce
);

    logic [CYC_W-1:0] cnt;
    logic [CYC_W-1:0] lim;
    logic             src_tick;

    // Pick the live tick and the terminal count of the active setting.
    always_comb begin
        src_tick = act_sub ? sub_tick : main_tick;
        lim      = act_sub ? CYC_W'(SUB_DIV - 1)
                           : CYC_W'(div_ratio(act_div) - 8'd1);
        cyc_end  = src_tick && (cnt == lim);
    end

    // Count source ticks and take the new setting on the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            act_sub <= 1'b0;
            act_div <= DIV64;
        end else if (cyc_end) begin
            cnt     <= '0;
            act_sub <= sel_sub;
            act_div <= sel_div;
        end else if (src_tick) begin
            cnt     <= cnt + 1'b1;
        end
    end

    // Register the gated enable pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cpu_ce <= 1'b0;
        else
            cpu_ce <= cyc_end && !halt_q && !stop_q;
    end

endmodule

// File: rtl/ckc_prescale.sv
// Peripheral prescaler. A free counter of main clocks gives a tap every
// 2^(PRE_MIN+sel) clocks. The select is clamped to the counter width.
// Assumes the tap select is held steady while in use.
module ckc_prescale #(
    parameter int PRE_W   = 12,
    parameter int PRE_MIN = 3,
    localparam int SEL_W  = 4,
    localparam int KW     = $clog2(PRE_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             main_tick,
    input  logic [SEL_W-1:0] tap_sel,
    output logic             per_ce
);

    localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(PRE_W - PRE_MIN);

    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] mask;
    logic [SEL_W-1:0] sel_c;
    logic [KW-1:0]    k;

    // Build the low-bit mask for the clamped tap.
    always_comb begin
        sel_c = (tap_sel > SEL_MAX) ? SEL_MAX : tap_sel;
        k     = KW'(PRE_MIN) + KW'(sel_c);
        mask  = ~({PRE_W{1'b1}} << k);
    end

    // Advance the prescaler on each running main clock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pre <= '0;
        else if (main_tick)
            pre <= pre + 1'b1;
    end

    // Fire the tap when all masked bits are set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            per_ce <= 1'b0;
        else
            per_ce <= main_tick && ((pre & mask) == mask);
    end

endmodule

// File: rtl/cpuclk_ctrl.sv
// CPU clock controller top. It ties the mode registers, the sleep flops,
// the cycle generator and the prescaler together. The main oscillator
// runs unless deep sleep is set, or the off bit is set while the
// subsystem source is active.
module cpuclk_ctrl
    import ckc_pkg::*;
#(
    parameter int SUB_DIV = 4,
    parameter int PRE_W   = 12,
    parameter int PRE_MIN = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sub_tick,
    input  logic       pcc_we,
    input  logic [3:0] pcc_wdata,
    input  logic       scc_we,
    input  logic [1:0] scc_wdata,
    input  logic       halt_cmd,
    input  logic       stop_cmd,
    input  logic       irq_rel,
    input  logic       wt_rel,
    input  logic [3:0] tap_sel,
    output logic       cpu_ce,
    output logic       per_ce,
    output logic       main_run,
    output logic       halted,
    output logic       stopped,
    output logic [3:0] pcc_q,
    output logic [1:0] scc_q,
    output logic       src_sub
);

    div_e act_div;
    logic cyc_end;

    ckc_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .pcc_we    (pcc_we),
        .pcc_wdata (pcc_wdata),
        .scc_we    (scc_we),
        .scc_wdata (scc_wdata),
        .stop_cmd  (stop_cmd),
        .pcc_q     (pcc_q),
        .scc_q     (scc_q)
    );

    ckc_standby u_stby (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt_cmd (halt_cmd),
        .stop_cmd (stop_cmd),
        .irq_rel  (irq_rel),
        .wt_rel   (wt_rel),
        .halt_q   (halted),
        .stop_q   (stopped)
    );

    // Oscillator enable from the freeze flop and the guarded off bit.
    always_comb main_run = !stopped && !(scc_q[1] && src_sub);

    ckc_cycle #(.SUB_DIV(SUB_DIV)) u_cyc (
        .clk       (clk),
        .rst_n     (rst_n),
        .main_tick (main_run),
        .sub_tick  (sub_tick),
        .sel_sub   (scc_q[0]),
        .sel_div   (pcc_decode(pcc_q[1:0])),
        .halt_q    (halted),
        .stop_q    (stopped),
        .act_sub   (src_sub),
        .act_div   (act_div),
        .cyc_end   (cyc_end),
        .cpu_ce    (cpu_ce)
    );

    ckc_prescale #(.PRE_W(PRE_W), .PRE_MIN(PRE_MIN)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .main_tick (main_run),
        .tap_sel   (tap_sel),
        .per_ce    (per_ce)
    );

endmodule

// File: rtl/cpuclk_ctrl_chk.sv
// Property checker for the CPU clock controller, bound into the top.
module cpuclk_ctrl_chk
    import ckc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_ce,
    input logic       per_ce,
    input logic       main_run,
    input logic       halted,
    input logic       stopped,
    input logic [3:0] pcc_q,
    input logic [1:0] scc_q,
    input logic       src_sub,
    input logic       stop_cmd,
    input logic       cyc_end,
    input div_e       act_div
);

    // R4
    boundary_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_end |=> ($stable(act_div) && $stable(src_sub)));

    // R5
    off_needs_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scc_q[1] |-> scc_q[0]);

    // R6
    osc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scc_q[1] && src_sub) |-> !main_run);

    // R7
    halt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && $past(halted)) |-> !cpu_ce);

    // R8
    stop_silence_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && $past(stopped)) |-> (!cpu_ce && !per_ce));

    // R8
    stop_pcc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_cmd |=> (pcc_q[3:2] == 2'b00));

endmodule

bind cpuclk_ctrl cpuclk_ctrl_chk u_chk (.*);

// File: tb/sim_cpuclk_ctrl.sv
// Bench for the CPU clock controller: period sweeps and release paths.
module sim_cpuclk_ctrl;

    localparam int SUBP = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sub_tick = 1'b0;
    logic       pcc_we = 1'b0;
    logic [3:0] pcc_wdata = 4'd0;
    logic       scc_we = 1'b0;
    logic [1:0] scc_wdata = 2'd0;
    logic       halt_cmd = 1'b0;
    logic       stop_cmd = 1'b0;
    logic       irq_rel = 1'b0;
    logic       wt_rel = 1'b0;
    logic [3:0] tap_sel = 4'd0;
    logic       cpu_ce, per_ce, main_run, halted, stopped, src_sub;
    logic [3:0] pcc_q;
    logic [1:0] scc_q;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    cpuclk_ctrl u0 (.*);

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Subsystem strobe every SUBP clocks.
    initial begin
        forever begin
            repeat (SUBP - 1) @(negedge clk);
            sub_tick = 1'b1;
            @(negedge clk);
            sub_tick = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cpu(output int t);
        int n = 0;
        @(negedge clk);
        while (!cpu_ce && n < 20000) begin
            @(negedge clk);
            n++;
        end
        t = cyc;
    endtask

    task automatic wait_per(output int t);
        int n = 0;
        @(negedge clk);
        while (!per_ce && n < 20000) begin
            @(negedge clk);
            n++;
        end
        t = cyc;
    endtask

    task automatic cpu_period(output int p);
        int a, b;
        wait_cpu(a);
        wait_cpu(a);
        wait_cpu(b);
        p = b - a;
    endtask

    task automatic per_period(output int p);
        int a, b;
        wait_per(a);
        wait_per(a);
        wait_per(b);
        p = b - a;
    endtask

    task automatic count_pulses(input int n, output int nc, output int np);
        nc = 0;
        np = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (cpu_ce) nc++;
            if (per_ce) np++;
        end
    endtask

    task automatic wr_pcc(input logic [3:0] v);
        @(negedge clk);
        pcc_wdata = v;
        pcc_we = 1'b1;
        @(negedge clk);
        pcc_we = 1'b0;
    endtask

    task automatic wr_scc(input logic [1:0] v);
        @(negedge clk);
        scc_wdata = v;
        scc_we = 1'b1;
        @(negedge clk);
        scc_we = 1'b0;
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk);
        s = 1'b1;
        @(negedge clk);
        s = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(5ns * 150000);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int p, t0, t1, t2, nc, np;
        do_reset();

        // R1 reset state and default period
        chk(pcc_q == 0 && scc_q == 0, "R1 regs", {pcc_q, 2'b0, scc_q}, 0);
        chk(!halted && !stopped && main_run && !src_sub, "R1 flags",
            {halted, stopped, main_run, src_sub}, 2);
        cpu_period(p);
        chk(p == 64, "R1 period", p, 64);

        // R2 every divide code
        for (int e = 0; e < 4; e++) begin
            int exp;
            exp = (e == 3) ? 4 : (e == 2) ? 8 : 64;
            wr_pcc(4'(e));
            cpu_period(p);
            chk(p == exp, "R2 period", p, exp);
        end

        // R4 change mid-cycle completes the old 64-clock cycle
        wr_pcc(4'd0);
        cpu_period(p);
        wait_cpu(t0);
        repeat (5) @(negedge clk);
        wr_pcc(4'd3);
        wait_cpu(t1);
        wait_cpu(t2);
        chk(t1 - t0 == 64, "R4 old cycle", t1 - t0, 64);
        chk(t2 - t1 == 4, "R4 new cycle", t2 - t1, 4);

        // R5 off bit refused while source bit stored as 0
        wr_scc(2'b10);
        chk(scc_q == 2'b00, "R5 off alone", scc_q, 0);
        wr_scc(2'b11);
        chk(scc_q == 2'b01, "R5 off before sub", scc_q, 1);

        // R3 subsystem period
        cpu_period(p);
        chk(p == 4 * SUBP, "R3 sub period", p, 4 * SUBP);
        chk(src_sub == 1'b1, "R3 src_sub", src_sub, 1);

        // R6 oscillator off under subsystem source
        wr_scc(2'b11);
        chk(scc_q == 2'b11, "R5 off accepted", scc_q, 3);
        chk(main_run == 1'b0, "R6 main_run", main_run, 0);
        count_pulses(300, nc, np);
        chk(np == 0, "R6 per silent", np, 0);
        cpu_period(p);
        chk(p == 4 * SUBP, "R6 sub period", p, 4 * SUBP);

        // back to main at /4
        wr_scc(2'b00);
        cpu_period(p);
        chk(p == 4 && !src_sub && main_run, "R3 return main", p, 4);

        // R9 every tap and a clamped select
        for (int s = 0; s <= 10; s++) begin
            int exp;
            tap_sel = (s == 10) ? 4'd12 : 4'(s);
            exp = 1 << (3 + ((s > 9) ? 9 : s));
            per_period(p);
            chk(p == exp, "R9 tap period", p, exp);
        end
        tap_sel = 4'd0;

        // R7 light sleep and interrupt wake
        pulse(halt_cmd);
        chk(halted == 1'b1, "R7 halted set", halted, 1);
        repeat (2) @(negedge clk);
        count_pulses(200, nc, np);
        chk(nc == 0, "R7 cpu gated", nc, 0);
        chk(np == 25, "R7 per runs", np, 25);
        pulse(wt_rel);
        chk(halted == 1'b1, "R7 wt_rel ignored", halted, 1);
        pulse(irq_rel);
        chk(halted == 1'b0, "R7 released", halted, 0);
        cpu_period(p);
        chk(p == 4, "R7 resume", p, 4);

        // R8 deep sleep, wrong and right release
        wr_pcc(4'hF);
        pulse(stop_cmd);
        chk(stopped && !main_run, "R8 stopped", {stopped, main_run}, 2);
        chk(pcc_q == 4'h3, "R8 pcc upper cleared", pcc_q, 3);
        repeat (2) @(negedge clk);
        count_pulses(200, nc, np);
        chk(nc == 0 && np == 0, "R8 silent", nc + np, 0);
        pulse(irq_rel);
        chk(stopped == 1'b1, "R8 irq ignored", stopped, 1);
        pulse(wt_rel);
        chk(!stopped && main_run, "R8 released", {stopped, main_run}, 1);
        cpu_period(p);
        chk(p == 4, "R8 resume", p, 4);

        // R10 reset clears both sleep flops
        pulse(halt_cmd);
        pulse(stop_cmd);
        chk(halted && stopped, "R10 both set", {halted, stopped}, 3);
        do_reset();
        chk(!halted && !stopped, "R10 cleared", {halted, stopped}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule